// File: doc/BRIEF.md
# Serial EEPROM Command and Poll Sequencer

This block sits on the host side of a single-wire serial EEPROM link. It turns an operation request into the exact order of bytes the memory expects, and hands each one to a separate bit-level transmitter. The four operations are: read the status byte, write the status byte, clear the whole array, and fill the whole array. With every byte it states whether the host acknowledge that follows should be a continue (MAK) or a stop (NoMAK). It checks the slave acknowledge the transmitter reports for every byte.

Before a clear or fill, the sequencer always reads the status byte and refuses to go on if any protection bit is set. In the automatic mode, a write-enable command goes out ahead of a status write, clear or fill. After the write starts, one status-read command stays open: each returned status byte is answered with MAK for as long as its busy bit is 1. This tracks the internal write to its end without sending the header again. A parameter limits how many status bytes are polled.

The transmitter interface works one transfer at a time. `xfer_valid` is a one-cycle strike, and the fields stay steady until `xfer_done`. A transfer is one of three kinds: send a byte, receive a byte, or send a host acknowledge.

Top module: `eesq_seq`

## Requirements
- R1: Every command frame begins with a send of the header byte (default 0x55) with MAK, then the device byte (default 0xA0) with MAK, then the command code. The codes are 0x05 read status, 0x6E write status, 0x96 write enable, 0x6D clear all and 0x67 fill all. Transfer kinds are encoded 0 send, 1 receive and 2 host acknowledge, and `xfer_mak` is 1 for MAK.
- R2: For a status write (op 1), the command code is sent with MAK. The data byte follows with NoMAK, which ends the frame.
- R3: For clear all (op 2) and fill all (op 3), the command code itself is sent with NoMAK and ends the frame.
- R4: Clear and fill always start with a status-read frame. If status bits [3:2] are not both 0, the run ends with error code 2 and no further byte is sent.
- R5: In automatic mode, ops 1 to 3 send a write-enable frame ending in NoMAK. That frame must be fully acknowledged before the write frame is issued. Outside automatic mode, no write-enable frame is sent.
- R6: In automatic mode, after a write frame, one status-read frame is held open. Each received byte with bit 0 = 1 is answered with MAK and followed by another receive. The first byte with bit 0 = 0 is answered with NoMAK, and the run ends with error code 0.
- R7: If the POLL_MAX-th polled byte still has bit 0 = 1, it is answered with NoMAK and the run ends with error code 3.
- R8: A missing slave acknowledge on any send or host acknowledge other than the header ends the run at once. The error code is 1 and `err_pos` gives the frame position: 1 device, 2 command, 3 data or status. A missing acknowledge on the header is ignored. `err_pos` is 0 for the other error codes.
- R9: A status read (op 0) sends one read-status frame, receives one byte and answers it with NoMAK. `status_out` then shows that byte, with or without the automatic mode.
- R10: `xfer_valid` is never high in two cycles in a row. `done` is a single-cycle pulse with `busy` low, and a start request while busy is ignored.
- R11: After reset, `busy`, `done`, `xfer_valid`, `err_code` and `status_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Start pulse, taken only while idle |
| req_op | input | 2 | 0 read status, 1 write status, 2 clear all, 3 fill all |
| req_wdata | input | 8 | Status value for op 1 |
| req_auto | input | 1 | Add write enable and completion polling |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 ok, 1 missing acknowledge, 2 protected, 3 poll timeout |
| err_pos | output | 2 | Frame position of a missing acknowledge |
| status_out | output | 8 | Last status byte received |
| xfer_valid | output | 1 | One-cycle transfer request |
| xfer_kind | output | 2 | 0 send, 1 receive, 2 host acknowledge |
| xfer_byte | output | 8 | Byte to send |
| xfer_mak | output | 1 | 1 MAK, 0 NoMAK after the byte |
| xfer_done | input | 1 | Transfer finished |
| xfer_sak | input | 1 | Slave acknowledge seen for the transfer |
| xfer_rdata | input | 8 | Received byte on a receive transfer |

## Verification
A wrong command selection or step counter shows on the very next `xfer_valid` strike as an unexpected byte, kind or MAK bit, so the transfer log is compared entry by entry. A poll counter that is off by one shows as one receive too many or too few at the POLL_MAX boundary, and as the wrong final error code. A wrong protection decision or lost acknowledge check shows within the same run as extra bytes after the point where the run should have ended.

// File: rtl/eesq_pkg.sv
package eesq_pkg;

  typedef enum logic [1:0] {
    OP_STAT_RD   = 2'd0,
    OP_STAT_WR   = 2'd1,
    OP_CLEAR_ALL = 2'd2,
    OP_FILL_ALL  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    XK_SEND = 2'd0,
    XK_RECV = 2'd1,
    XK_ACK  = 2'd2
  } xkind_e;

  typedef enum logic [1:0] {
    CM_PEEK   = 2'd0,
    CM_ENABLE = 2'd1,
    CM_MAIN   = 2'd2,
    CM_POLL   = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ER_NONE    = 2'd0,
    ER_NOACK   = 2'd1,
    ER_PROTECT = 2'd2,
    ER_TIMEOUT = 2'd3
  } err_e;

  localparam int STEP_W = 3;
  localparam logic [STEP_W-1:0] STEP_HDR  = 3'd0;
  localparam logic [STEP_W-1:0] STEP_DEV  = 3'd1;
  localparam logic [STEP_W-1:0] STEP_CMD  = 3'd2;
  localparam logic [STEP_W-1:0] STEP_BODY = 3'd3;
  localparam logic [STEP_W-1:0] STEP_ACK  = 3'd4;

  function automatic logic guard_set(input logic [7:0] s);
    return s[3] | s[2];
  endfunction

  function automatic logic write_busy(input logic [7:0] s);
    return s[0];
  endfunction

  function automatic logic is_bulk(input op_e op);
    return (op == OP_CLEAR_ALL) || (op == OP_FILL_ALL);
  endfunction

  function automatic logic reads_status(input cmd_e c, input op_e op);
    return (c == CM_PEEK) || (c == CM_POLL) || ((c == CM_MAIN) && (op == OP_STAT_RD));
  endfunction

  function automatic logic [1:0] frame_pos(input logic [STEP_W-1:0] step);
    return (step >= STEP_BODY) ? 2'd3 : step[1:0];
  endfunction

  function automatic cmd_e first_cmd(input op_e op, input logic auto_mode);
    if (is_bulk(op))                         return CM_PEEK;
    else if (op == OP_STAT_WR && auto_mode)  return CM_ENABLE;
    else                                     return CM_MAIN;
  endfunction

endpackage

// File: rtl/eesq_frame.sv
module eesq_frame
  import eesq_pkg::*;
#(
  parameter logic [7:0] HDR_BYTE     = 8'h55,
  parameter logic [7:0] DEV_BYTE     = 8'hA0,
  parameter logic [7:0] CODE_STAT_RD = 8'h05,
  parameter logic [7:0] CODE_STAT_WR = 8'h6E,
  parameter logic [7:0] CODE_WEN     = 8'h96,
  parameter logic [7:0] CODE_CLEAR   = 8'h6D,
  parameter logic [7:0] CODE_FILL    = 8'h67
) (
  input  cmd_e              cmd,
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  input  logic [7:0]        wdata,
  input  logic              ack_more,
  output xkind_e            kind,
  output logic [7:0]        byte_o,
  output logic              mak
);

  logic [7:0] opcode;
  logic       cmd_final;
  logic       rd_frame;

  always_comb begin
    unique case (cmd)
      CM_PEEK, CM_POLL: opcode = CODE_STAT_RD;
      CM_ENABLE:        opcode = CODE_WEN;
      default: begin
        unique case (op)
          OP_STAT_RD:   opcode = CODE_STAT_RD;
          OP_STAT_WR:   opcode = CODE_STAT_WR;
          OP_CLEAR_ALL: opcode = CODE_CLEAR;
          default:      opcode = CODE_FILL;
        endcase
      end
    endcase
    rd_frame  = reads_status(cmd, op);
    cmd_final = (cmd == CM_ENABLE) || ((cmd == CM_MAIN) && is_bulk(op));
  end

  always_comb begin
    kind   = XK_SEND;
    byte_o = 8'h00;
    mak    = 1'b1;
    unique case (step)
      STEP_HDR: byte_o = HDR_BYTE;
      STEP_DEV: byte_o = DEV_BYTE;
      STEP_CMD: begin
        byte_o = opcode;
        mak    = ~cmd_final;
      end
      STEP_BODY: begin
        if (rd_frame) begin
          kind = XK_RECV;
          mak  = 1'b0;
        end else begin
          byte_o = wdata;
          mak    = 1'b0;
        end
      end
      default: begin
        kind = XK_ACK;
        mak  = ack_more;
      end
    endcase
  end

endmodule

// File: rtl/eesq_poll.sv
module eesq_poll #(
  parameter int POLL_MAX = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rx_stb,
  input  logic rx_wip,
  input  logic active,
  output logic more,
  output logic expired
);

  localparam int CW = $clog2(POLL_MAX + 1);
  localparam logic [CW:0] LIM = (CW + 1)'(POLL_MAX);

  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt} + 1'b1;
  assign more    = active & rx_wip & (cnt_nxt < LIM);
  assign expired = active & rx_wip & (cnt_nxt >= LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                            cnt <= '0;
    else if (clr)                                          cnt <= '0;
    else if (rx_stb && active && ({1'b0, cnt} < LIM))      cnt <= cnt_nxt[CW-1:0];
  end

  AST_POLL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} <= LIM); // R7

  AST_EXPIRE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(more && expired)); // R7

endmodule

// File: rtl/eesq_seq.sv
module eesq_seq
  import eesq_pkg::*;
#(
  parameter logic [7:0] HDR_BYTE     = 8'h55,
  parameter logic [7:0] DEV_BYTE     = 8'hA0,
  parameter logic [7:0] CODE_STAT_RD = 8'h05,
  parameter logic [7:0] CODE_STAT_WR = 8'h6E,
  parameter logic [7:0] CODE_WEN     = 8'h96,
  parameter logic [7:0] CODE_CLEAR   = 8'h6D,
  parameter logic [7:0] CODE_FILL    = 8'h67,
  parameter int         POLL_MAX     = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_start,
  input  logic [1:0] req_op,
  input  logic [7:0] req_wdata,
  input  logic       req_auto,
  output logic       busy,
  output logic       done,
  output logic [1:0] err_code,
  output logic [1:0] err_pos,
  output logic [7:0] status_out,
  output logic       xfer_valid,
  output logic [1:0] xfer_kind,
  output logic [7:0] xfer_byte,
  output logic       xfer_mak,
  input  logic       xfer_done,
  input  logic       xfer_sak,
  input  logic [7:0] xfer_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e               state;
  op_e               op_q;
  cmd_e              cmd_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        wdata_q;
  logic              auto_q;
  logic              ack_more_q;
  logic              tout_q;
  logic [7:0]        status_q;
  logic              done_q;
  err_e              err_q;
  logic [1:0]        pos_q;

  xkind_e            fr_kind;
  logic [7:0]        fr_byte;
  logic              fr_mak;

  eesq_frame #(
    .HDR_BYTE(HDR_BYTE), .DEV_BYTE(DEV_BYTE), .CODE_STAT_RD(CODE_STAT_RD),
    .CODE_STAT_WR(CODE_STAT_WR), .CODE_WEN(CODE_WEN),
    .CODE_CLEAR(CODE_CLEAR), .CODE_FILL(CODE_FILL)
  ) u_frame (
    .cmd(cmd_q), .op(op_q), .step(step_q), .wdata(wdata_q),
    .ack_more(ack_more_q), .kind(fr_kind), .byte_o(fr_byte), .mak(fr_mak)
  );

  // named internal events
  logic xfer_evt, sak_miss, cmd_close, poll_clr, rx_stb;
  logic poll_more, poll_expired;
  logic [STEP_W-1:0] step_next;

  assign xfer_evt  = (state == ST_WAIT) && xfer_done;
  assign sak_miss  = xfer_evt && (fr_kind != XK_RECV) && (step_q != STEP_HDR) && !xfer_sak;
  assign cmd_close = xfer_evt && !sak_miss && (fr_kind != XK_RECV) && !fr_mak;
  assign poll_clr  = (state == ST_ISSUE) && (step_q == STEP_HDR);
  assign rx_stb    = xfer_evt && (fr_kind == XK_RECV);

  eesq_poll #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .rx_stb(rx_stb),
    .rx_wip(write_busy(xfer_rdata)), .active(cmd_q == CM_POLL),
    .more(poll_more), .expired(poll_expired)
  );

  always_comb begin
    unique case (fr_kind)
      XK_RECV: step_next = STEP_ACK;
      XK_ACK:  step_next = STEP_BODY;
      default: step_next = step_q + 1'b1;
    endcase
  end

  // decision at the end of a frame
  logic fin_go;
  err_e fin_code;
  cmd_e nxt_cmd;

  always_comb begin
    fin_go   = 1'b0;
    fin_code = ER_NONE;
    nxt_cmd  = cmd_q;
    unique case (cmd_q)
      CM_PEEK: begin
        if (guard_set(status_q)) begin
          fin_go   = 1'b1;
          fin_code = ER_PROTECT;
        end else begin
          nxt_cmd = auto_q ? CM_ENABLE : CM_MAIN;
        end
      end
      CM_ENABLE: nxt_cmd = CM_MAIN;
      CM_MAIN: begin
        if (op_q == OP_STAT_RD || !auto_q) fin_go = 1'b1;
        else                               nxt_cmd = CM_POLL;
      end
      default: begin
        fin_go   = 1'b1;
        fin_code = tout_q ? ER_TIMEOUT : ER_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      op_q       <= OP_STAT_RD;
      cmd_q      <= CM_MAIN;
      step_q     <= STEP_HDR;
      wdata_q    <= '0;
      auto_q     <= 1'b0;
      ack_more_q <= 1'b0;
      tout_q     <= 1'b0;
      status_q   <= '0;
      done_q     <= 1'b0;
      err_q      <= ER_NONE;
      pos_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_start) begin
            op_q       <= op_e'(req_op);
            wdata_q    <= req_wdata;
            auto_q     <= req_auto;
            cmd_q      <= first_cmd(op_e'(req_op), req_auto);
            step_q     <= STEP_HDR;
            ack_more_q <= 1'b0;
            tout_q     <= 1'b0;
            state      <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        default: begin
          if (xfer_evt) begin
            if (rx_stb) begin
              status_q   <= xfer_rdata;
              ack_more_q <= poll_more;
              tout_q     <= poll_expired;
            end
            if (sak_miss) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
              err_q  <= ER_NOACK;
              pos_q  <= frame_pos(step_q);
            end else if (cmd_close) begin
              if (fin_go) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
                err_q  <= fin_code;
                pos_q  <= '0;
              end else begin
                cmd_q      <= nxt_cmd;
                step_q     <= STEP_HDR;
                ack_more_q <= 1'b0;
                state      <= ST_ISSUE;
              end
            end else begin
              step_q <= step_next;
              state  <= ST_ISSUE;
            end
          end
        end
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign err_code   = err_q;
  assign err_pos    = pos_q;
  assign status_out = status_q;
  assign xfer_valid = (state == ST_ISSUE);
  assign xfer_kind  = fr_kind;
  assign xfer_byte  = fr_byte;
  assign xfer_mak   = fr_mak;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> !xfer_valid); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && $past(state) == ST_WAIT) |-> ($stable(xfer_byte) && $stable(xfer_mak) && $stable(xfer_kind))); // R10

  AST_MAK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_kind == 2'd2 && xfer_mak) |-> status_q[0]); // R6

  AST_PROTECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd2) |-> (status_q[3:2] != 2'b00)); // R4

  AST_TIMEOUT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 2'd3) |-> (!ack_more_q && status_q[0])); // R7

endmodule

// File: tb/eesq_seq_test.sv
module eesq_seq_test;

  localparam int PMAX = 6;
  localparam logic [7:0] HDR = 8'h55, DEV = 8'hA0;
  localparam logic [7:0] C_RD = 8'h05, C_WR = 8'h6E, C_WEN = 8'h96, C_CLR = 8'h6D, C_FIL = 8'h67;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_start = 1'b0;
  logic [1:0] req_op = '0;
  logic [7:0] req_wdata = '0;
  logic req_auto = 1'b0;
  logic busy, done, xfer_valid, xfer_mak;
  logic [1:0] err_code, err_pos, xfer_kind;
  logic [7:0] status_out, xfer_byte;
  logic xfer_done, xfer_sak;
  logic [7:0] xfer_rdata;

  always #5 clk = ~clk;

  eesq_seq #(.POLL_MAX(PMAX)) uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
    .req_wdata(req_wdata), .req_auto(req_auto), .busy(busy), .done(done),
    .err_code(err_code), .err_pos(err_pos), .status_out(status_out),
    .xfer_valid(xfer_valid), .xfer_kind(xfer_kind), .xfer_byte(xfer_byte),
    .xfer_mak(xfer_mak), .xfer_done(xfer_done), .xfer_sak(xfer_sak),
    .xfer_rdata(xfer_rdata)
  );

  int n_chk = 0, n_fail = 0;

  // expected transfer list: {kind, mak, byte}
  logic [10:0] exp_v [64];
  logic [1:0]  exp_pos [64];
  logic [7:0]  exp_st [64];
  int exp_n, exp_err, exp_idx, trig_idx;
  logic [7:0] prev_stat = 8'h00;
  logic [7:0] run_st;

  // slave model state
  logic [10:0] log_v [64];
  int log_n = 0;
  int nack_at = -1;
  int poll_left = 0;
  logic [1:0] m_bp = 2'b00;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
    end
  endtask

  function automatic logic [7:0] stat_byte(input logic [1:0] bp, input bit wip);
    return {4'b0000, bp, 1'b1, wip};
  endfunction

  task automatic push(input logic [1:0] k, input bit m, input logic [7:0] b, input logic [1:0] p);
    exp_v[exp_n]   = {k, m, b};
    exp_pos[exp_n] = p;
    exp_st[exp_n]  = run_st;
    exp_n++;
  endtask

  task automatic build(input int op, input bit au, input logic [1:0] bp, input int wipn, input logic [7:0] data);
    exp_n = 0; exp_err = 0; exp_idx = 0; trig_idx = -1; run_st = prev_stat;
    if (op >= 2) begin
      push(2'd0, 1, HDR, 2'd0); push(2'd0, 1, DEV, 2'd1); push(2'd0, 1, C_RD, 2'd2);
      run_st = stat_byte(bp, 0); push(2'd1, 0, 8'h00, 2'd3); push(2'd2, 0, 8'h00, 2'd3);
      if (bp != 2'b00) begin exp_err = 2; return; end
    end
    if (au && op != 0) begin
      push(2'd0, 1, HDR, 2'd0); push(2'd0, 1, DEV, 2'd1); push(2'd0, 0, C_WEN, 2'd2);
    end
    push(2'd0, 1, HDR, 2'd0); push(2'd0, 1, DEV, 2'd1);
    case (op)
      0: begin
        push(2'd0, 1, C_RD, 2'd2);
        run_st = stat_byte(bp, 0); push(2'd1, 0, 8'h00, 2'd3); push(2'd2, 0, 8'h00, 2'd3);
      end
      1: begin push(2'd0, 1, C_WR, 2'd2); trig_idx = exp_n; push(2'd0, 0, data, 2'd3); end
      2: begin trig_idx = exp_n; push(2'd0, 0, C_CLR, 2'd2); end
      default: begin trig_idx = exp_n; push(2'd0, 0, C_FIL, 2'd2); end
    endcase
    if (au && op != 0) begin
      push(2'd0, 1, HDR, 2'd0); push(2'd0, 1, DEV, 2'd1); push(2'd0, 1, C_RD, 2'd2);
      for (int i = 1; i <= PMAX; i++) begin
        bit w;
        w = (i <= wipn);
        run_st = stat_byte(bp, w);
        push(2'd1, 0, 8'h00, 2'd3);
        if (!w) begin push(2'd2, 0, 8'h00, 2'd3); break; end
        else if (i == PMAX) begin push(2'd2, 0, 8'h00, 2'd3); exp_err = 3; break; end
        else push(2'd2, 1, 8'h00, 2'd3);
      end
    end
  endtask

  // slave model driving the transfer handshake
  initial begin
    xfer_done = 1'b0; xfer_sak = 1'b0; xfer_rdata = 8'h00;
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (xfer_valid) begin
        int k;
        logic [7:0] rd;
        k = log_n;
        if (k < 64) log_v[k] = {xfer_kind, xfer_mak, xfer_byte};
        log_n++;
        rd = 8'h00;
        if (xfer_kind == 2'd1) begin
          bit w;
          w = (trig_idx >= 0) && (k > trig_idx) && (poll_left > 0);
          if (w) poll_left--;
          rd = stat_byte(m_bp, w);
        end
        repeat (1 + ($urandom % 3)) @(negedge clk);
        xfer_done = 1'b1; xfer_sak = (k != nack_at); xfer_rdata = rd;
      end
    end
  end

  // nack: -1 none, -2 random eligible, >=0 explicit transfer index
  task automatic run_case(input int op, input bit au, input logic [1:0] bp, input int wipn,
                          input logic [7:0] data, input int nack, input bit poke, input string rq);
    int k;
    bit got;
    logic [7:0] fin_st;
    build(op, au, bp, wipn, data);
    k = nack;
    if (nack == -2) begin
      int cnt;
      cnt = 0;
      for (int i = 1; i < exp_n; i++) if (exp_v[i][10:9] != 2'd1) cnt++;
      k = -1;
      if (cnt > 0) begin
        int pick;
        pick = $urandom % cnt;
        for (int i = 1; i < exp_n; i++) if (exp_v[i][10:9] != 2'd1) begin
          if (pick == 0 && k < 0) k = i;
          pick--;
        end
      end
    end
    if (k > 0) begin
      exp_n = k + 1; exp_err = 1; exp_idx = exp_pos[k];
    end
    fin_st = exp_st[exp_n - 1];
    m_bp = bp; poll_left = wipn; nack_at = k; log_n = 0;
    @(negedge clk);
    req_op = op[1:0]; req_auto = au; req_wdata = data; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req_op = 2'd0; req_auto = 1'b0; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
    end
    got = 0;
    for (int c = 0; c < 4000; c++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R10 done pulse", got, 1);
    chk(!busy, "R10 busy low at done", busy, 0);
    @(negedge clk);
    chk(!done, "R10 done single cycle", done, 0);
    chk(err_code == exp_err[1:0], {rq, " err_code"}, err_code, exp_err);
    chk(err_pos == exp_idx[1:0], "R8 err_pos", err_pos, exp_idx);
    chk(status_out == fin_st, (op == 0) ? "R9 status_out" : {rq, " status_out"}, status_out, fin_st);
    chk(log_n == exp_n, {rq, " transfer count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n && i < 64; i++)
      chk(log_v[i] == exp_v[i], {rq, " transfer"}, {21'd0, log_v[i]}, {21'd0, exp_v[i]});
    prev_stat = fin_st;
    repeat (2) @(negedge clk);
    chk(log_n == exp_n, "R10 no transfer after done", log_n, exp_n);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !xfer_valid, "R11 idle outputs", {busy, done, xfer_valid}, 0);
    chk(err_code == 2'd0 && status_out == 8'h00, "R11 err/status", {err_code, status_out}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !xfer_valid, "R11 idle after release", {busy, xfer_valid}, 0);

    run_case(0, 1, 2'b01, 0, 8'h00, -1, 0, "R9");
    run_case(1, 0, 2'b00, 0, 8'h0C, -1, 0, "R2");
    run_case(1, 1, 2'b00, 2, 8'h08, -1, 0, "R5");
    run_case(2, 1, 2'b00, 0, 8'h00, -1, 0, "R3");
    run_case(3, 0, 2'b00, 0, 8'h00, -1, 0, "R3");
    run_case(3, 1, 2'b10, 3, 8'h00, -1, 0, "R4");
    run_case(2, 0, 2'b11, 0, 8'h00, -1, 0, "R4");
    run_case(2, 1, 2'b00, PMAX, 8'h00, -1, 0, "R7");
    run_case(3, 1, 2'b00, PMAX - 1, 8'h00, -1, 0, "R6");
    run_case(1, 1, 2'b00, PMAX + 1, 8'h04, -1, 0, "R7");
    run_case(0, 0, 2'b00, 0, 8'h00, 0, 0, "R8");
    run_case(0, 0, 2'b00, 0, 8'h00, 1, 0, "R8");
    run_case(2, 1, 2'b00, 2, 8'h00, 4, 0, "R8");
    run_case(2, 1, 2'b00, 4, 8'h00, -2, 0, "R8");
    run_case(3, 1, 2'b00, 3, 8'h00, -1, 1, "R10");

    for (int t = 0; t < 40; t++) begin
      int op, wn, nk;
      bit au;
      logic [1:0] bp;
      op = $urandom % 4;
      au = $urandom % 2;
      bp = (($urandom % 4) == 0) ? 2'(1 + ($urandom % 3)) : 2'b00;
      wn = $urandom % (PMAX + 2);
      nk = (($urandom % 4) == 0) ? -2 : -1;
      run_case(op, au, bp, wn, 8'($urandom), nk, 0, "R1");
    end

    summary();
    $finish;
  end

endmodule